// File: doc/BRIEF.md
# Machine-Level Interrupt Arbiter

This block decides whether the hart must take a machine-level interrupt and which cause code the trap unit should report. Three raw request lines (software, timer, external) are captured each cycle into a pending view. That view is read-only. Each pending source is then masked by its own bit in a software-writable enable register. Whatever is left is qualified by the global machine interrupt enable, which comes from the status register.

Software reaches the enable and pending views through a small CSR port. A write strobe with address and data stores the enable bits. A combinational read returns the addressed view. When more than one enabled source is pending, a fixed priority picks one. The resulting cause code goes straight to the trap unit, which uses it for vectored entry. The interrupt flag of the full cause word is implied by the request strobe.

Top module: `mirq_arbiter`

## Requirements
- R1: After reset, the enable view and the pending view both read zero, `irq_req_o` is 0 and `irq_cause_o` is 0.
- R2: A write to address 0x304 stores data bits 3 (software), 7 (timer) and 11 (external) as the enable bits. A read of 0x304 returns those bits in the same positions and zero everywhere else.
- R3: The pending view at address 0x344 is read-only. A write to 0x344 changes neither the pending view nor the enable view.
- R4: Pending bits 3, 7 and 11 of the view at 0x344 show the software, timer and external lines as sampled at the previous clock edge. They set and clear with the line, one cycle later.
- R5: A pending source can raise `irq_req_o` only while its enable bit is 1. An enable bit of 0 masks that source.
- R6: While `glb_ie_i` is 0, `irq_req_o` is 0, whatever the enable and pending bits hold.
- R7: The cause code is 3 for a software interrupt, 7 for a timer interrupt and 11 for an external interrupt.
- R8: When several enabled sources are pending together, the external source wins, then software, then timer.
- R9: While `irq_req_o` is 0, `irq_cause_o` is 0.
- R10: A read of any address other than 0x304 or 0x344 returns zero. A write to such an address leaves the enable view unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_irq_i | input | 1 | Raw machine software interrupt line |
| tmr_irq_i | input | 1 | Raw machine timer interrupt line |
| ext_irq_i | input | 1 | Raw machine external interrupt line |
| glb_ie_i | input | 1 | Global machine interrupt enable from the status register |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | Combinational CSR read data for `csr_addr_i` |
| irq_req_o | output | 1 | An interrupt must be taken |
| irq_cause_o | output | XLEN-1 | Cause code of the winning source |

## Verification
The hardest case to reach from the ports is a conflict between all three sources. It needs every line held high, every enable bit written and the global enable on, all at once. Only then does the priority order decide the cause. The bench first builds that state. It then withdraws the winning line one cycle at a time, so that each step exposes the next source in line after the one-cycle capture delay. A second pass keeps all three lines pending and moves only the enable mask. This shows that masking alone changes the winner.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
   localparam int NSRC = 3;

   localparam int POS_SW  = 3;
   localparam int POS_TMR = 7;
   localparam int POS_EXT = 11;

   localparam logic [11:0] ADDR_EN   = 12'h304;
   localparam logic [11:0] ADDR_PEND = 12'h344;

   // internal source index in priority order: 0 is highest
   function automatic int src_pos(input int idx);
      case (idx)
         0:       return POS_EXT;
         1:       return POS_SW;
         default: return POS_TMR;
      endcase
   endfunction
endpackage

// File: rtl/mirq_enable_reg.sv
module mirq_enable_reg
   import mirq_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [XLEN-1:0]      wdata,
   output logic [NSRC-1:0]      en_q
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      localparam int P = src_pos(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     en_q[i] <= 1'b0;
         else if (wr_en) en_q[i] <= wdata[P];
      end
   end

   a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q));
endmodule

// File: rtl/mirq_pend_capture.sv
module mirq_pend_capture
   import mirq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lines_i,
   output logic [NSRC-1:0] pend_q
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= lines_i[i];
      end
   end

   a_r4_follows_lines: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_q == $past(lines_i)));
endmodule

// File: rtl/mirq_prio.sv
module mirq_prio
   import mirq_pkg::*;
#(
   parameter int CAUSE_W = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC-1:0]    pend_i,
   input  logic [NSRC-1:0]    en_i,
   input  logic               glb_ie_i,
   output logic               req_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic [NSRC-1:0] hit;

   always_comb begin
      hit     = pend_i & en_i & {NSRC{glb_ie_i}};
      req_o   = |hit;
      cause_o = '0;
      // lowest priority first, higher ones overwrite
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (hit[i]) cause_o = CAUSE_W'(src_pos(i));
      end
   end

   a_r8_external_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_ie_i && pend_i[0] && en_i[0]) |-> (cause_o == CAUSE_W'(POS_EXT)));
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !req_o |-> (cause_o == '0));
   a_r5_needs_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> ((pend_i & en_i) != '0));
endmodule

// File: rtl/mirq_arbiter.sv
module mirq_arbiter
   import mirq_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int CAUSE_W = XLEN - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_irq_i,
   input  logic               tmr_irq_i,
   input  logic               ext_irq_i,
   input  logic               glb_ie_i,
   input  logic [11:0]        csr_addr_i,
   input  logic               csr_we_i,
   input  logic [XLEN-1:0]    csr_wdata_i,
   output logic [XLEN-1:0]    csr_rdata_o,
   output logic               irq_req_o,
   output logic [CAUSE_W-1:0] irq_cause_o
);
   if (XLEN < 16) begin : g_bad_xlen
      $error("mirq_arbiter: XLEN must be at least 16");
   end

   logic [NSRC-1:0] lines;
   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] pend_q;
   logic [XLEN-1:0] en_view;
   logic [XLEN-1:0] pend_view;
   logic            en_wr;

   assign lines = {tmr_irq_i, sw_irq_i, ext_irq_i};
   assign en_wr = csr_we_i && (csr_addr_i == ADDR_EN);

   mirq_enable_reg #(.XLEN(XLEN)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (en_wr),
      .wdata (csr_wdata_i),
      .en_q  (en_q)
   );

   mirq_pend_capture u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (lines),
      .pend_q  (pend_q)
   );

   mirq_prio #(.CAUSE_W(CAUSE_W)) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_i   (pend_q),
      .en_i     (en_q),
      .glb_ie_i (glb_ie_i),
      .req_o    (irq_req_o),
      .cause_o  (irq_cause_o)
   );

   always_comb begin
      en_view   = '0;
      pend_view = '0;
      for (int i = 0; i < NSRC; i++) begin
         en_view[src_pos(i)]   = en_q[i];
         pend_view[src_pos(i)] = pend_q[i];
      end
   end

   always_comb begin
      case (csr_addr_i)
         ADDR_EN:   csr_rdata_o = en_view;
         ADDR_PEND: csr_rdata_o = pend_view;
         default:   csr_rdata_o = '0;
      endcase
   end

   a_r6_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_ie_i |-> !irq_req_o);
   a_r3_pend_write_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we_i && csr_addr_i == ADDR_PEND) |=> $stable(en_q));
endmodule

// File: tb/mirq_arbiter_tb.sv
module mirq_arbiter_tb;
   localparam int XLEN = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sw_irq_i = 1'b0, tmr_irq_i = 1'b0, ext_irq_i = 1'b0;
   logic              glb_ie_i = 1'b0;
   logic [11:0]       csr_addr_i = '0;
   logic              csr_we_i = 1'b0;
   logic [XLEN-1:0]   csr_wdata_i = '0;
   logic [XLEN-1:0]   csr_rdata_o;
   logic              irq_req_o;
   logic [XLEN-2:0]   irq_cause_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mirq_arbiter #(.XLEN(XLEN)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .sw_irq_i(sw_irq_i), .tmr_irq_i(tmr_irq_i), .ext_irq_i(ext_irq_i),
      .glb_ie_i(glb_ie_i),
      .csr_addr_i(csr_addr_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
      .csr_rdata_o(csr_rdata_o), .irq_req_o(irq_req_o), .irq_cause_o(irq_cause_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
      csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1;
      tick();
      csr_we_i = 1'b0;
   endtask

   task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
      csr_addr_i = a;
      #1;
      d = csr_rdata_o;
   endtask

   task automatic set_lines(input logic s, input logic t, input logic e);
      sw_irq_i = s; tmr_irq_i = t; ext_irq_i = e;
      tick();
   endtask

   task automatic t_reset();
      logic [31:0] d;
      csr_rd(12'h304, d); chk("R1 enable view", d, 32'h0);
      csr_rd(12'h344, d); chk("R1 pending view", d, 32'h0);
      chk("R1 req", 32'(irq_req_o), 32'h0);
      chk("R1 cause", 32'(irq_cause_o), 32'h0);
   endtask

   task automatic t_enable_rw();
      logic [31:0] d;
      csr_wr(12'h304, 32'hFFFF_FFFF);
      csr_rd(12'h304, d); chk("R2 all ones masked", d, 32'h888);
      csr_wr(12'h304, 32'h0000_0080);
      csr_rd(12'h304, d); chk("R2 timer only", d, 32'h080);
      csr_wr(12'h304, 32'h0);
      csr_rd(12'h304, d); chk("R2 cleared", d, 32'h0);
   endtask

   task automatic t_pending_ro();
      logic [31:0] d;
      csr_wr(12'h344, 32'hFFFF_FFFF);
      csr_rd(12'h344, d); chk("R3 pending unwritable", d, 32'h0);
      csr_rd(12'h304, d); chk("R3 enable untouched", d, 32'h0);
   endtask

   task automatic t_pending_follow();
      logic [31:0] d;
      tmr_irq_i = 1'b1;
      csr_rd(12'h344, d); chk("R4 not yet captured", d, 32'h0);
      tick();
      csr_rd(12'h344, d); chk("R4 timer captured", d, 32'h080);
      set_lines(1'b1, 1'b0, 1'b1);
      csr_rd(12'h344, d); chk("R4 sw+ext captured", d, 32'h808);
      set_lines(1'b0, 1'b0, 1'b0);
      csr_rd(12'h344, d); chk("R4 cleared", d, 32'h0);
   endtask

   task automatic t_mask();
      glb_ie_i = 1'b1;
      set_lines(1'b1, 1'b1, 1'b1);
      chk("R5 all masked req", 32'(irq_req_o), 32'h0);
      chk("R9 masked cause zero", 32'(irq_cause_o), 32'h0);
      csr_wr(12'h304, 32'h080);
      chk("R5 timer enabled req", 32'(irq_req_o), 32'h1);
      chk("R7 timer cause", 32'(irq_cause_o), 32'd7);
      csr_wr(12'h304, 32'h008);
      chk("R7 software cause", 32'(irq_cause_o), 32'd3);
      csr_wr(12'h304, 32'h088);
      chk("R8 software beats timer by mask", 32'(irq_cause_o), 32'd3);
      set_lines(1'b0, 1'b0, 1'b0);
      chk("R5 no pending no req", 32'(irq_req_o), 32'h0);
   endtask

   task automatic t_global();
      csr_wr(12'h304, 32'h888);
      set_lines(1'b1, 1'b1, 1'b1);
      glb_ie_i = 1'b0;
      #1;
      chk("R6 global off req", 32'(irq_req_o), 32'h0);
      chk("R9 global off cause", 32'(irq_cause_o), 32'h0);
      glb_ie_i = 1'b1;
      #1;
      chk("R6 global on req", 32'(irq_req_o), 32'h1);
   endtask

   task automatic t_priority();
      csr_wr(12'h304, 32'h888);
      set_lines(1'b1, 1'b1, 1'b1);
      chk("R8 external first", 32'(irq_cause_o), 32'd11);
      set_lines(1'b1, 1'b1, 1'b0);
      chk("R8 software second", 32'(irq_cause_o), 32'd3);
      set_lines(1'b0, 1'b1, 1'b0);
      chk("R8 timer last", 32'(irq_cause_o), 32'd7);
      set_lines(1'b0, 1'b0, 1'b1);
      chk("R7 external cause", 32'(irq_cause_o), 32'd11);
      set_lines(1'b0, 1'b0, 1'b0);
      chk("R9 idle cause", 32'(irq_cause_o), 32'd0);
   endtask

   task automatic t_other_addr();
      logic [31:0] d;
      csr_wr(12'h304, 32'h808);
      csr_wr(12'h300, 32'hFFFF_FFFF);
      csr_rd(12'h304, d); chk("R10 enable unchanged", d, 32'h808);
      csr_rd(12'h300, d); chk("R10 other reads zero", d, 32'h0);
      csr_wr(12'h305, 32'h0);
      csr_rd(12'h304, d); chk("R10 near address ignored", d, 32'h808);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_enable_rw();
      t_pending_ro();
      t_pending_follow();
      t_mask();
      t_global();
      t_priority();
      t_other_addr();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule